// File: doc/BRIEF.md
# Chained Framed Serial Port

This block is the device-side serial port of a multichannel sampling device. Several identical devices can share one host serial link by chaining them. Each device sends 16-bit words most significant bit first. An output frame strobe goes high for one clock in the cycle before each word's first bit. The device draws its own words from a local queue of channel samples. A common start pulse begins a sample period, and all devices in the chain receive it in the same cycle.

Each device's data and frame outputs drive the data and frame inputs of the next device, and the host listens to the last device. In every channel slot a device first sends its own word. For the rest of the slot, its outputs carry whatever arrived on its inputs exactly one word time earlier. As a result, the device nearest the host is heard first and the device farthest from the host is heard last. One idle bit period separates consecutive slots.

A small receiver also watches the data input. It reassembles every framed word it sees there and reports each one with a single-cycle strobe.

Top module: `chain_port`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `sdo_o`, `sfo_o`, `q_pop_o` and `rx_valid_o` are 0.
- R2: When the port is idle and `start_i` is high in cycle s, `sfo_o` is high in cycle s+1. The device's own word then appears on `sdo_o` in cycles s+2 to s+17, most significant bit first.
- R3: In each own-frame cycle, `q_pop_o` is high exactly when `q_valid_i` is high, and the word sent is `q_data_i` from that cycle. If `q_valid_i` is low, an all-zero word is sent and nothing is popped.
- R4: A sample period contains `num_ch_m1_i`+1 own words. Consecutive own frames are 16·(`dev_cnt_i`+1)+1 cycles apart, where `dev_cnt_i` holds the chain length minus one and 000 means a single device.
- R5: Outside the 16 cycles that carry the device's own word, `sdo_o` in cycle t equals `sdi_i` in cycle t-16.
- R6: A high level on `sfi_i` in cycle t makes `sfo_o` high in cycle t+16. A forwarded word therefore follows the own word back to back, with its frame strobe during the own word's last bit.
- R7: With a single device (count 000), one bit period without data separates successive own words: the frame comes 17 cycles after the previous frame.
- R8: A word framed on `sfi_i` in cycle c, with bits in cycles c+1 to c+16, is presented on `rx_word_o` with `rx_valid_o` high for the single cycle c+17.
- R9: A frame strobe on `sfi_i` that coincides with the last bit of a word being received starts the next word. Both words are delivered 16 cycles apart.
- R10: While a period is running, `start_i` is ignored. `dev_cnt_i` and `num_ch_m1_i` are sampled only at the start of a period.
- R11: When two devices are chained with count 001, the host receives, in order: near device channel 1, far device channel 1, near device channel 2, far device channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a sample period when idle |
| dev_cnt_i | input | 3 | Chain length minus one |
| num_ch_m1_i | input | 3 | Words per period minus one |
| q_valid_i | input | 1 | Local queue holds a sample |
| q_data_i | input | 16 | Head of the local queue |
| q_pop_o | output | 1 | Head word consumed at this clock edge |
| sdi_i | input | 1 | Serial data from the upstream device or the host |
| sfi_i | input | 1 | Frame strobe from the upstream device or the host |
| sdo_o | output | 1 | Serial data toward the host |
| sfo_o | output | 1 | Frame strobe toward the host |
| rx_valid_o | output | 1 | Received word strobe |
| rx_word_o | output | 16 | Received word |

## Verification
If the slot counter holds a wrong value, the next own frame arrives early or late. That error shows on `sfo_o` at the next slot boundary, within at most 129 cycles. If the latched count is wrong, the frame spacing changes by a multiple of 16 cycles from the second slot onward. If the forwarding delay line has the wrong length, upstream words on `sdo_o` are shifted by whole bits, and the frame strobe no longer lines up with the own word's last bit; this shows within one word time. A receiver counter that is off by one delivers a corrupted word, or fires `rx_valid_o` a cycle early or late, 17 cycles after the frame.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
  // cycles from one own frame to the next
  function automatic int unsigned slot_len(input int unsigned word_w, input int unsigned dc);
    return word_w * (dc + 1) + 1;
  endfunction
endpackage

// File: rtl/chain_port_sched.sv
module chain_port_sched #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  dev_cnt_i,
  input  logic [CH_W-1:0]   num_ch_m1_i,
  output logic              own_fr_o,
  output logic              ld_o
);
  logic              busy_q;
  logic [SLOT_W-1:0] cyc_q, last_cyc;
  logic [CH_W-1:0]   ch_left_q;
  logic [CNT_W-1:0]  dc_q;
  logic              slot_end;

  always_comb begin
    last_cyc = SLOT_W'(chain_port_pkg::slot_len(WORD_W, 32'(dc_q)) - 1);
    slot_end = busy_q && (cyc_q == last_cyc);
    own_fr_o = (!busy_q && start_i) || (slot_end && (ch_left_q != '0));
    ld_o     = busy_q && (cyc_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cyc_q     <= '0;
      ch_left_q <= '0;
      dc_q      <= '0;
    end else if (own_fr_o) begin
      busy_q <= 1'b1;
      cyc_q  <= '0;
      if (!busy_q) begin
        dc_q      <= dev_cnt_i;
        ch_left_q <= num_ch_m1_i;
      end else begin
        ch_left_q <= ch_left_q - 1'b1;
      end
    end else if (slot_end) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/chain_port_tx.sv
module chain_port_tx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_fr_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sdi_i,
  input  logic              sfi_i,
  output logic              sdo_o,
  output logic              sfo_o
);
  localparam int unsigned FD_W = WORD_W - 1;

  logic [WORD_W-1:0] d_q;
  logic [FD_W-1:0]   f_q;
  logic              sfo_q;

  // one word-long line: own word loaded in, upstream bits shift in behind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q   <= '0;
      f_q   <= '0;
      sfo_q <= 1'b0;
    end else begin
      if (ld_i) d_q <= word_i;
      else      d_q <= {d_q[WORD_W-2:0], sdi_i};
      f_q   <= {f_q[FD_W-2:0], sfi_i};
      sfo_q <= own_fr_i | f_q[FD_W-1];
    end
  end

  assign sdo_o = d_q[WORD_W-1];
  assign sfo_o = sfo_q;
endmodule

// File: rtl/chain_port_rx.sv
module chain_port_rx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              sfi_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int unsigned RC_W = $clog2(WORD_W + 1);

  logic [RC_W-1:0]   cnt_q;
  logic [WORD_W-1:0] sr_q, word_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (cnt_q == RC_W'(1));
      if (cnt_q == RC_W'(1)) word_q <= {sr_q[WORD_W-2:0], sdi_i};
      if (cnt_q != '0) begin
        sr_q  <= {sr_q[WORD_W-2:0], sdi_i};
        cnt_q <= cnt_q - 1'b1;
      end
      if (sfi_i) cnt_q <= RC_W'(WORD_W);
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_word_o  = word_q;
endmodule

// File: rtl/chain_port.sv
module chain_port #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  dev_cnt_i,
  input  logic [CH_W-1:0]   num_ch_m1_i,
  input  logic              q_valid_i,
  input  logic [WORD_W-1:0] q_data_i,
  output logic              q_pop_o,
  input  logic              sdi_i,
  input  logic              sfi_i,
  output logic              sdo_o,
  output logic              sfo_o,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int unsigned SLOT_W = $clog2(WORD_W * (2 ** CNT_W) + 2);

  logic              own_fr, ld;
  logic [WORD_W-1:0] own_word;

  assign q_pop_o  = ld & q_valid_i;
  assign own_word = q_valid_i ? q_data_i : '0;

  chain_port_sched #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .CH_W(CH_W), .SLOT_W(SLOT_W)
  ) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dev_cnt_i   (dev_cnt_i),
    .num_ch_m1_i (num_ch_m1_i),
    .own_fr_o    (own_fr),
    .ld_o        (ld)
  );

  chain_port_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .own_fr_i (own_fr),
    .ld_i     (ld),
    .word_i   (own_word),
    .sdi_i    (sdi_i),
    .sfi_i    (sfi_i),
    .sdo_o    (sdo_o),
    .sfo_o    (sfo_o)
  );

  chain_port_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sdi_i      (sdi_i),
    .sfi_i      (sfi_i),
    .rx_valid_o (rx_valid_o),
    .rx_word_o  (rx_word_o)
  );
endmodule

// File: rtl/chain_port_chk.sv
module chain_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic own_fr_i,
  input logic ld_i,
  input logic q_pop_i,
  input logic q_valid_i,
  input logic sfo_i,
  input logic rx_valid_i
);
  a_r2_own_frame_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_fr_i |=> sfo_i);
  a_r3_pop_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop_i |-> q_valid_i);
  a_r3_pop_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop_i |-> sfo_i);
  a_r4_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> !ld_i);
  a_r8_rx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);
endmodule

bind chain_port chain_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .own_fr_i   (own_fr),
  .ld_i       (ld),
  .q_pop_i    (q_pop_o),
  .q_valid_i  (q_valid_i),
  .sfo_i      (sfo_o),
  .rx_valid_i (rx_valid_o)
);

// File: tb/chain_port_tb.sv
module chain_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  dev_cnt = '0, num_ch = '0;
  logic        q_valid = 1'b0, up_q_valid;
  logic [15:0] q_data, up_q_data;
  logic        pop, up_pop;
  logic        sdi, sfi, sdo, sfo, up_sdo, up_sfo;
  logic        rxv, up_rxv;
  logic [15:0] rxw, up_rxw;
  logic        chain_en = 1'b0, pat_sdi = 1'b0, pat_sfi = 1'b0;

  logic [15:0] q0 [4];
  logic [15:0] q1 [4];
  logic [1:0]  r0 = '0, r1 = '0;
  logic        pop_seen0 = 1'b0, pop_seen1 = 1'b0;

  assign q_data     = q0[r0];
  assign up_q_data  = q1[r1];
  assign up_q_valid = chain_en;
  assign sdi = chain_en ? up_sdo : pat_sdi;
  assign sfi = chain_en ? up_sfo : pat_sfi;

  int checks = 0, errors = 0;

  chain_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_cnt_i(dev_cnt),
    .num_ch_m1_i(num_ch), .q_valid_i(q_valid), .q_data_i(q_data), .q_pop_o(pop),
    .sdi_i(sdi), .sfi_i(sfi), .sdo_o(sdo), .sfo_o(sfo),
    .rx_valid_o(rxv), .rx_word_o(rxw)
  );

  chain_port u_up (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_cnt_i(dev_cnt),
    .num_ch_m1_i(num_ch), .q_valid_i(up_q_valid), .q_data_i(up_q_data), .q_pop_o(up_pop),
    .sdi_i(1'b0), .sfi_i(1'b0), .sdo_o(up_sdo), .sfo_o(up_sfo),
    .rx_valid_o(up_rxv), .rx_word_o(up_rxw)
  );

  // queue heads advance after the edge that consumed them
  always @(negedge clk) begin
    if (pop_seen0) r0 <= r0 + 1'b1;
    if (pop_seen1) r1 <= r1 + 1'b1;
    pop_seen0 <= pop;
    pop_seen1 <= up_pop;
  end

  logic        ps_sdi [0:79];
  logic        ps_sfi [0:79];
  logic        ps_start [0:79];
  logic [2:0]  ps_dc [0:79];
  logic [2:0]  ps_nc [0:79];
  logic        cap_sfo [0:79];
  logic        cap_sdo [0:79];
  logic        cap_pop [0:79];
  logic        cap_rxv [0:79];
  logic [15:0] cap_rxw [0:79];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_pat(input logic [2:0] dc, input logic [2:0] nc);
    for (int i = 0; i < 80; i++) begin
      ps_sdi[i] = 1'b0; ps_sfi[i] = 1'b0; ps_start[i] = 1'b0;
      ps_dc[i] = dc; ps_nc[i] = nc;
    end
  endtask

  task automatic put_word(input int at, input logic [15:0] w);
    ps_sfi[at-1] = 1'b1;
    for (int b = 0; b < 16; b++) ps_sdi[at+b] = w[15-b];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0; pat_sdi = 1'b0; pat_sfi = 1'b0;
    r0 = '0; r1 = '0; pop_seen0 = 1'b0; pop_seen1 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_sfo[i] = sfo; cap_sdo[i] = sdo; cap_pop[i] = pop;
      cap_rxv[i] = rxv; cap_rxw[i] = rxw;
      pat_sdi = ps_sdi[i]; pat_sfi = ps_sfi[i]; start = ps_start[i];
      dev_cnt = ps_dc[i]; num_ch = ps_nc[i];
    end
    @(negedge clk);
    start = 1'b0; pat_sdi = 1'b0; pat_sfi = 1'b0;
  endtask

  function automatic logic [15:0] word_at(input int at);
    logic [15:0] w;
    for (int b = 0; b < 16; b++) w[15-b] = cap_sdo[at+b];
    return w;
  endfunction

  // compares frame strobes over [0,n) with the listed cycles
  task automatic chk_frames(input string req, input int n, input int f0, input int f1,
                            input int f2, input int f3);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      e = (i == f0) || (i == f1) || (i == f2) || (i == f3);
      if (cap_sfo[i] != e) bad++;
    end
    chk(req, "frame strobe cycles mismatching", bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "sdo in reset", int'(sdo), 0);
    chk("R1", "sfo in reset", int'(sfo), 0);
    chk("R1", "pop in reset", int'(pop), 0);
    chk("R1", "rx_valid in reset", int'(rxv), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sfo after reset", int'(sfo), 0);
    chk("R1", "sdo after reset", int'(sdo), 0);
  endtask

  task automatic t_single();
    do_reset();
    q0[0] = 16'hA5C3; q0[1] = 16'h1234; q_valid = 1'b1; chain_en = 1'b0;
    clr_pat(3'd0, 3'd1);
    ps_start[0] = 1'b1;
    run(45);
    chk_frames("R4", 45, 1, 18, -1, -1);
    chk("R7", "second frame one idle bit later", int'(cap_sfo[18]), 1);
    chk("R2", "first own word", int'(word_at(2)), 16'hA5C3);
    chk("R2", "first word MSB cycle", int'(cap_sdo[2]), 1);
    chk("R3", "second own word", int'(word_at(19)), 16'h1234);
    chk("R3", "pop at first frame", int'(cap_pop[1]), 1);
    chk("R3", "pop at second frame", int'(cap_pop[18]), 1);
  endtask

  task automatic t_empty();
    int pops = 0;
    do_reset();
    q0[0] = 16'hFFFF; q_valid = 1'b0; chain_en = 1'b0;
    clr_pat(3'd0, 3'd0);
    ps_start[0] = 1'b1;
    run(25);
    for (int i = 0; i < 25; i++) pops += int'(cap_pop[i]);
    chk("R3", "zero word on empty queue", int'(word_at(2)), 0);
    chk("R3", "no pop on empty queue", pops, 0);
    chk("R2", "frame still sent", int'(cap_sfo[1]), 1);
  endtask

  task automatic t_forward();
    do_reset();
    q0[0] = 16'hC001; q0[1] = 16'hC002; q_valid = 1'b1; chain_en = 1'b0;
    clr_pat(3'd1, 3'd1);
    ps_start[0] = 1'b1;
    put_word(2, 16'hBEEF);
    put_word(35, 16'h0F0F);
    run(72);
    chk_frames("R6", 72, 1, 17, 34, 50);
    chk("R4", "own frame spacing 33", int'(cap_sfo[34]), 1);
    chk("R2", "own word slot 1", int'(word_at(2)), 16'hC001);
    chk("R5", "forwarded word slot 1", int'(word_at(18)), 16'hBEEF);
    chk("R3", "own word slot 2", int'(word_at(35)), 16'hC002);
    chk("R5", "forwarded word slot 2", int'(word_at(51)), 16'h0F0F);
  endtask

  task automatic t_ignore();
    int pops = 0;
    do_reset();
    q0[0] = 16'h5A5A; q0[1] = 16'h3C3C; q_valid = 1'b1; chain_en = 1'b0;
    clr_pat(3'd0, 3'd0);
    ps_start[0] = 1'b1;
    ps_start[5] = 1'b1;
    for (int i = 3; i < 80; i++) begin ps_dc[i] = 3'd3; ps_nc[i] = 3'd4; end
    run(45);
    for (int i = 0; i < 45; i++) pops += int'(cap_pop[i]);
    chk_frames("R10", 45, 1, -1, -1, -1);
    chk("R10", "single pop despite second start", pops, 1);
    chk("R10", "word unaffected", int'(word_at(2)), 16'h5A5A);
  endtask

  task automatic t_rx();
    int strobes = 0;
    do_reset();
    q_valid = 1'b0; chain_en = 1'b0;
    clr_pat(3'd0, 3'd0);
    put_word(4, 16'h8001);
    put_word(20, 16'h7E5A);
    run(45);
    for (int i = 0; i < 45; i++) strobes += int'(cap_rxv[i]);
    chk("R8", "rx strobe at c+17", int'(cap_rxv[20]), 1);
    chk("R8", "rx word", int'(cap_rxw[20]), 16'h8001);
    chk("R9", "back-to-back rx strobe", int'(cap_rxv[36]), 1);
    chk("R9", "back-to-back rx word", int'(cap_rxw[36]), 16'h7E5A);
    chk("R8", "strobe count", strobes, 2);
  endtask

  task automatic t_chain();
    do_reset();
    q0[0] = 16'h2001; q0[1] = 16'h2002;
    q1[0] = 16'h1001; q1[1] = 16'h1002;
    q_valid = 1'b1; chain_en = 1'b1;
    clr_pat(3'd1, 3'd1);
    ps_start[0] = 1'b1;
    run(72);
    chk_frames("R11", 72, 1, 17, 34, 50);
    chk("R11", "near ch1", int'(word_at(2)), 16'h2001);
    chk("R11", "far ch1", int'(word_at(18)), 16'h1001);
    chk("R11", "near ch2", int'(word_at(35)), 16'h2002);
    chk("R11", "far ch2", int'(word_at(51)), 16'h1002);
    chain_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin q0[i] = '0; q1[i] = '0; end
    t_reset();
    t_single();
    t_empty();
    t_forward();
    t_ignore();
    t_rx();
    t_chain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule